// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the control heart of a small microprogrammed 16-bit load/store processor. It holds a 6-bit microprogram state, reads the matching 35-bit microinstruction from a 64-entry control store, and presents the 26 datapath control bits of that word on `ctrl_word`. The other 9 bits steer the sequencer itself: a 6-bit jump target, a 2-bit condition select and a dispatch flag.

The next state is not taken from an encoded transition table. The jump target is used as the base, and one condition signal may be OR-ed into one of its three low bits:
- memory ready goes into bit 1,
- the latched branch-enable goes into bit 2,
- instruction bit 11 (addressing mode) goes into bit 0.

When the dispatch flag is set, the next state is instead `{2'b00, instr[15:12]}`, which is a 16-way branch on the opcode.

The branch-enable is computed from instruction bits 11..9 and the N/Z/P condition codes. It is captured in a flag register only in a microinstruction that asks for it.

There is no data stream at the block's edge, so no valid/ready pair is used. `mem_ready` is the only flow-control pin: a read state simply repeats while it is low.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `state` is 18 (the fetch start state).
- R2: For an unconditional microinstruction (condition 00, no dispatch), the next state is the jump target. The fetch path is 18 -> 33 and 35 -> 32. States 22, 20, 21, 27 and 44 return to 18. Every opcode state not named in R5-R9 also returns to 18.
- R3: State 33 repeats while `mem_ready` is 0 and moves to 35 in the cycle after `mem_ready` is 1 (bit 1 of the jump target 33 is set by ready).
- R4: State 32 dispatches. The next state equals `instr[15:12]` with two zero bits above it.
- R5: In state 32 a flag BEN is captured as `(instr[11]&cc_n)|(instr[10]&cc_z)|(instr[9]&cc_p)`. In state 0, the next state is 22 when BEN is 1 and 18 otherwise (BEN OR-ed into bit 2 of jump target 18).
- R6: Changes on `instr[11:9]` or on the condition codes after state 32 have no effect on the branch decision taken in state 0.
- R7: State 4 goes to 21 when `instr[11]` is 1 and to 20 when it is 0 (addressing-mode bit into bit 0 of jump target 20).
- R8: Opcodes 10 and 11 are not implemented. Their states 10 and 11 both go to state 44, which then returns to 18.
- R9: State 6 goes to 25. State 25 repeats while `mem_ready` is 0, then moves to 27.
- R10: `ctrl_word` bit 0 (memory enable) is 1 exactly in states 33 and 25. `ctrl_word` bit 1 (branch-flag load) is 1 exactly in state 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction register contents |
| cc_n | input | 1 | Negative condition code |
| cc_z | input | 1 | Zero condition code |
| cc_p | input | 1 | Positive condition code |
| mem_ready | input | 1 | Memory has completed the current access |
| ctrl_word | output | 26 | Datapath control bits of the current microinstruction |
| state | output | 6 | Current microprogram state number |

## Verification
The embedded properties check, on every cycle, several rules that involve only one or two consecutive states:
- the reset landing state and the dispatch target,
- the hold of the wait states while memory is not ready,
- the exits from the addressing-mode and illegal-opcode states,
- that the branch flag only moves in a load cycle.

Some behaviour is only visible across a whole sequence, so only the bench scenarios can show it:
- a full fetch with a varying number of wait cycles,
- taken and not-taken branches whose condition inputs change after the flag is captured,
- correct control bits in each state along mixed random instruction streams.

// File: rtl/useq_pkg.sv
package useq_pkg;
  parameter int ADDR_W  = 6;
  parameter int OPC_W   = 4;
  parameter int DP_W    = 26;
  parameter int INSTR_W = 16;

  typedef enum logic [1:0] {
    SEQ_UNCOND = 2'b00,
    SEQ_MEMRDY = 2'b01,
    SEQ_BRANCH = 2'b10,
    SEQ_AMODE  = 2'b11
  } seq_cond_e;

  typedef struct packed {
    logic [ADDR_W-1:0] jump;
    seq_cond_e         cond;
    logic              dispatch;
    logic [DP_W-1:0]   dp;
  } uinst_t;

  // datapath control bit positions
  localparam int DP_MEM_EN    = 0;
  localparam int DP_LD_BEN    = 1;
  localparam int DP_LD_MAR    = 2;
  localparam int DP_LD_MDR    = 3;
  localparam int DP_LD_IR     = 4;
  localparam int DP_LD_PC     = 5;
  localparam int DP_LD_REG    = 6;
  localparam int DP_LD_CC     = 7;
  localparam int DP_GATE_PC   = 8;
  localparam int DP_GATE_MDR  = 9;
  localparam int DP_GATE_ALU  = 10;
  localparam int DP_GATE_ADDR = 11;
  localparam int DP_GATE_SHF  = 12;
  localparam int DP_PC_SEL    = 13; // 2 bits
  localparam int DP_DST_SEL   = 15;
  localparam int DP_SRC1_SEL  = 16;
  localparam int DP_BASE_SEL  = 17;
  localparam int DP_OFF_SEL   = 18; // 2 bits
  localparam int DP_MAR_SEL   = 20;
  localparam int DP_ALU_OP    = 21; // 2 bits
  localparam int DP_WRITE     = 23;
  localparam int DP_BYTE      = 24;
  localparam int DP_SHIFT1    = 25;

  // microprogram state numbers
  localparam logic [ADDR_W-1:0] S_BR       = 6'd0;
  localparam logic [ADDR_W-1:0] S_JSR      = 6'd4;
  localparam logic [ADDR_W-1:0] S_LDW      = 6'd6;
  localparam logic [ADDR_W-1:0] S_BAD_A    = 6'd10;
  localparam logic [ADDR_W-1:0] S_BAD_B    = 6'd11;
  localparam logic [ADDR_W-1:0] S_FETCH    = 6'd18;
  localparam logic [ADDR_W-1:0] S_JSR_REG  = 6'd20;
  localparam logic [ADDR_W-1:0] S_JSR_REL  = 6'd21;
  localparam logic [ADDR_W-1:0] S_BR_TAKE  = 6'd22;
  localparam logic [ADDR_W-1:0] S_LDW_RD   = 6'd25;
  localparam logic [ADDR_W-1:0] S_LDW_WB   = 6'd27;
  localparam logic [ADDR_W-1:0] S_DECODE   = 6'd32;
  localparam logic [ADDR_W-1:0] S_READ     = 6'd33;
  localparam logic [ADDR_W-1:0] S_LOAD_IR  = 6'd35;
  localparam logic [ADDR_W-1:0] S_BAD_TRAP = 6'd44;
endpackage

// File: rtl/useq_ctrl_rom.sv
module useq_ctrl_rom
  import useq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output uinst_t        word
);
  localparam int DEPTH = 1 << AW;

  function automatic uinst_t build(input logic [ADDR_W-1:0] a);
    uinst_t u;
    u      = '0;
    u.jump = S_FETCH;
    u.cond = SEQ_UNCOND;
    case (a)
      S_FETCH: begin
        u.jump = S_READ;
        u.dp[DP_LD_MAR] = 1'b1; u.dp[DP_GATE_PC] = 1'b1; u.dp[DP_LD_PC] = 1'b1;
      end
      S_READ: begin
        u.jump = S_READ; u.cond = SEQ_MEMRDY;
        u.dp[DP_MEM_EN] = 1'b1; u.dp[DP_LD_MDR] = 1'b1;
      end
      S_LOAD_IR: begin
        u.jump = S_DECODE;
        u.dp[DP_GATE_MDR] = 1'b1; u.dp[DP_LD_IR] = 1'b1;
      end
      S_DECODE: begin
        u.dispatch = 1'b1;
        u.dp[DP_LD_BEN] = 1'b1;
      end
      S_BR: begin
        u.jump = S_FETCH; u.cond = SEQ_BRANCH;
      end
      S_BR_TAKE: begin
        u.dp[DP_LD_PC] = 1'b1; u.dp[DP_PC_SEL +: 2] = 2'd2;
        u.dp[DP_OFF_SEL +: 2] = 2'd2; u.dp[DP_SHIFT1] = 1'b1;
      end
      S_JSR: begin
        u.jump = S_JSR_REG; u.cond = SEQ_AMODE;
        u.dp[DP_GATE_PC] = 1'b1; u.dp[DP_LD_REG] = 1'b1; u.dp[DP_DST_SEL] = 1'b1;
      end
      S_JSR_REG: begin
        u.dp[DP_LD_PC] = 1'b1; u.dp[DP_PC_SEL +: 2] = 2'd2; u.dp[DP_BASE_SEL] = 1'b1;
      end
      S_JSR_REL: begin
        u.dp[DP_LD_PC] = 1'b1; u.dp[DP_PC_SEL +: 2] = 2'd2;
        u.dp[DP_OFF_SEL +: 2] = 2'd3; u.dp[DP_SHIFT1] = 1'b1;
      end
      S_LDW: begin
        u.jump = S_LDW_RD;
        u.dp[DP_LD_MAR] = 1'b1; u.dp[DP_GATE_ADDR] = 1'b1; u.dp[DP_MAR_SEL] = 1'b1;
        u.dp[DP_BASE_SEL] = 1'b1; u.dp[DP_OFF_SEL +: 2] = 2'd1; u.dp[DP_SHIFT1] = 1'b1;
      end
      S_LDW_RD: begin
        u.jump = S_LDW_RD; u.cond = SEQ_MEMRDY;
        u.dp[DP_MEM_EN] = 1'b1; u.dp[DP_LD_MDR] = 1'b1;
      end
      S_LDW_WB: begin
        u.dp[DP_GATE_MDR] = 1'b1; u.dp[DP_LD_REG] = 1'b1; u.dp[DP_LD_CC] = 1'b1;
      end
      S_BAD_A, S_BAD_B: begin
        u.jump = S_BAD_TRAP;
        u.dp[DP_GATE_PC] = 1'b1; u.dp[DP_LD_REG] = 1'b1; u.dp[DP_DST_SEL] = 1'b1;
      end
      S_BAD_TRAP: begin
        u.dp[DP_LD_PC] = 1'b1; u.dp[DP_PC_SEL +: 2] = 2'd1;
      end
      6'd1, 6'd5, 6'd9: begin
        u.dp[DP_LD_REG] = 1'b1; u.dp[DP_LD_CC] = 1'b1; u.dp[DP_GATE_ALU] = 1'b1;
        u.dp[DP_SRC1_SEL] = 1'b1;
        u.dp[DP_ALU_OP +: 2] = (a == 6'd1) ? 2'd0 : ((a == 6'd5) ? 2'd1 : 2'd2);
      end
      6'd13: begin
        u.dp[DP_LD_REG] = 1'b1; u.dp[DP_LD_CC] = 1'b1; u.dp[DP_GATE_SHF] = 1'b1;
        u.dp[DP_SRC1_SEL] = 1'b1;
      end
      6'd12: begin
        u.dp[DP_LD_PC] = 1'b1; u.dp[DP_PC_SEL +: 2] = 2'd2; u.dp[DP_BASE_SEL] = 1'b1;
      end
      6'd14: begin
        u.dp[DP_LD_REG] = 1'b1; u.dp[DP_GATE_ADDR] = 1'b1;
        u.dp[DP_OFF_SEL +: 2] = 2'd2; u.dp[DP_SHIFT1] = 1'b1;
      end
      6'd2, 6'd3, 6'd7, 6'd15: begin
        u.dp[DP_LD_MAR] = 1'b1; u.dp[DP_GATE_ADDR] = 1'b1; u.dp[DP_MAR_SEL] = 1'b1;
        u.dp[DP_BYTE] = (a == 6'd2) || (a == 6'd3);
        u.dp[DP_WRITE] = (a == 6'd3) || (a == 6'd7);
      end
      default: u.jump = S_FETCH;
    endcase
    return u;
  endfunction

  uinst_t store [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign store[g] = build(ADDR_W'(g));
  end

  assign word = store[addr];
endmodule

// File: rtl/useq_branch_flag.sv
module useq_branch_flag (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] cc_mask,
  input  logic       cc_n,
  input  logic       cc_z,
  input  logic       cc_p,
  input  logic       load,
  output logic       ben_q
);
  logic ben_d;

  always_comb begin
    ben_d = (cc_mask[2] & cc_n) | (cc_mask[1] & cc_z) | (cc_mask[0] & cc_p);
  end

  always_ff @(posedge clk) begin
    if (rst)       ben_q <= 1'b0;
    else if (load) ben_q <= ben_d;
  end

  p_ben_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ben_q));
  p_ben_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (load && !(cc_mask[2] & cc_n) && !(cc_mask[1] & cc_z) && !(cc_mask[0] & cc_p))
    |=> !ben_q);
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OPC_W
) (
  input  logic [AW-1:0] jump,
  input  seq_cond_e     cond,
  input  logic          dispatch,
  input  logic [OW-1:0] opcode,
  input  logic          ben,
  input  logic          ready,
  input  logic          amode,
  output logic [AW-1:0] next
);
  localparam int PAD_W = AW - OW;
  logic [AW-1:0] modded;

  always_comb begin
    modded = jump;
    unique case (cond)
      SEQ_MEMRDY: modded[1] = jump[1] | ready;
      SEQ_BRANCH: modded[2] = jump[2] | ben;
      SEQ_AMODE:  modded[0] = jump[0] | amode;
      default:    modded = jump;
    endcase
    next = dispatch ? {{PAD_W{1'b0}}, opcode} : modded;
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = INSTR_W,
  parameter int CW = DP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] instr,
  input  logic          cc_n,
  input  logic          cc_z,
  input  logic          cc_p,
  input  logic          mem_ready,
  output logic [CW-1:0] ctrl_word,
  output logic [AW-1:0] state
);
  localparam int OPC_LSB = IW - OPC_W;

  logic [AW-1:0] state_q;
  logic [AW-1:0] next_state;
  uinst_t        uword;
  logic          ben;

  useq_ctrl_rom #(.AW(AW)) u_rom (
    .addr (state_q),
    .word (uword)
  );

  useq_branch_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .cc_mask (instr[11:9]),
    .cc_n    (cc_n),
    .cc_z    (cc_z),
    .cc_p    (cc_p),
    .load    (uword.dp[DP_LD_BEN]),
    .ben_q   (ben)
  );

  useq_next_addr #(.AW(AW), .OW(OPC_W)) u_next (
    .jump     (uword.jump),
    .cond     (uword.cond),
    .dispatch (uword.dispatch),
    .opcode   (instr[IW-1:OPC_LSB]),
    .ben      (ben),
    .ready    (mem_ready),
    .amode    (instr[11]),
    .next     (next_state)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_FETCH;
    else     state_q <= next_state;
  end

  assign state     = state_q;
  assign ctrl_word = uword.dp;

  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state_q == S_FETCH);
  p_dispatch_r4: assert property (@(posedge clk) disable iff (rst)
    state_q == S_DECODE |=> state_q == {2'b00, $past(instr[IW-1:OPC_LSB])});
  p_fetch_uncond_r2: assert property (@(posedge clk) disable iff (rst)
    state_q == S_FETCH |=> state_q == S_READ);
  p_read_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_READ && !mem_ready) |=> state_q == S_READ);
  p_ldw_wait_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_LDW_RD && !mem_ready) |=> state_q == S_LDW_RD);
  p_amode_r7: assert property (@(posedge clk) disable iff (rst)
    state_q == S_JSR |=> state_q == {5'b01010, $past(instr[11])});
  p_bad_exit_r8: assert property (@(posedge clk) disable iff (rst)
    state_q == S_BAD_TRAP |=> state_q == S_FETCH);
endmodule

// File: tb/useq_ctrl_test.sv
module useq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instr;
  logic        cc_n, cc_z, cc_p, mem_ready;
  logic [25:0] ctrl_word;
  logic [5:0]  state;

  int compared = 0;
  int mismatched = 0;
  int exp_state;
  bit exp_ben;
  string exp_tag;
  bit finished = 0;

  always #5 clk = ~clk;

  useq_ctrl uut (
    .clk(clk), .rst(rst), .instr(instr), .cc_n(cc_n), .cc_z(cc_z),
    .cc_p(cc_p), .mem_ready(mem_ready), .ctrl_word(ctrl_word), .state(state)
  );

  function automatic int model_next(int s, logic [15:0] ir, bit ben, bit rdy);
    case (s)
      18: return 33;
      33: return rdy ? 35 : 33;
      35: return 32;
      32: return int'(ir[15:12]);
      0:  return ben ? 22 : 18;
      4:  return ir[11] ? 21 : 20;
      6:  return 25;
      25: return rdy ? 27 : 25;
      10, 11: return 44;
      default: return 18;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      33: return "R3";
      32: return "R4";
      0:  return "R5";
      4:  return "R7";
      6, 25: return "R9";
      10, 11, 44: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // at a falling edge: check outputs, drive inputs, predict the next state
  task automatic step(logic [15:0] ir, bit n, bit z, bit p, bit rdy, string tag_ovr);
    check(exp_tag, int'(state), exp_state);
    check("R10", int'(ctrl_word[0]), int'(exp_state == 33 || exp_state == 25));
    check("R10", int'(ctrl_word[1]), int'(exp_state == 32));
    instr = ir; cc_n = n; cc_z = z; cc_p = p; mem_ready = rdy;
    exp_tag = (tag_ovr != "") ? tag_ovr : tag_of(exp_state);
    if (exp_state == 32) exp_ben = (ir[11] & n) | (ir[10] & z) | (ir[9] & p);
    exp_state = model_next(exp_state, ir, exp_ben, rdy);
    @(negedge clk);
  endtask

  // fetch with a given number of wait cycles, ending in state 32 checked
  task automatic fetch(int waits);
    step(16'h0, 0, 0, 0, 0, "");
    for (int w = 0; w < waits; w++) step(16'h0, 0, 0, 0, 0, "R3");
    step(16'h0, 0, 0, 0, 1, "R3");
    step(16'h0, 0, 0, 0, 0, "R2");
  endtask

  initial begin
    void'($urandom(32'h1a2b3c4d));
    rst = 1'b1; instr = '0; cc_n = 0; cc_z = 0; cc_p = 0; mem_ready = 0;
    exp_state = 18; exp_ben = 0; exp_tag = "R1";
    repeat (3) @(negedge clk);
    check("R1", int'(state), 18);
    mem_ready = 1;
    @(negedge clk);
    check("R1", int'(state), 18);
    rst = 1'b0;
    mem_ready = 0;

    // fetch with 3 waits, taken branch, conditions changed after latch
    fetch(3);
    step(16'h0400, 0, 1, 0, 0, "R4");          // BR with z mask, z=1
    step(16'h0000, 0, 0, 0, 0, "R6");          // inputs cleared: must still take
    step(16'h0, 0, 0, 0, 0, "R2");             // 22 -> 18
    // fetch with no wait, branch not taken although inputs later match
    fetch(0);
    step(16'h0800, 0, 1, 0, 0, "R4");          // n mask, n=0 -> BEN 0
    step(16'h0E00, 1, 1, 1, 0, "R6");          // would be 1 now: must not take
    // addressing mode both ways
    fetch(1);
    step(16'h4800, 0, 0, 0, 0, "R4");
    step(16'h4800, 0, 0, 0, 0, "R7");
    step(16'h0, 0, 0, 0, 0, "R2");
    fetch(2);
    step(16'h4000, 0, 0, 0, 0, "R4");
    step(16'h4000, 0, 0, 0, 0, "R7");
    step(16'h0, 0, 0, 0, 0, "R2");
    // load word with waits
    fetch(0);
    step(16'h6000, 0, 0, 0, 0, "R4");
    step(16'h0, 0, 0, 0, 0, "R9");
    for (int w = 0; w < 4; w++) step(16'h0, 0, 0, 0, 0, "R9");
    step(16'h0, 0, 0, 0, 1, "R9");
    step(16'h0, 0, 0, 0, 0, "R2");
    // illegal opcodes
    fetch(1);
    step(16'hA000, 0, 0, 0, 0, "R8");
    step(16'h0, 0, 0, 0, 0, "R8");
    step(16'h0, 0, 0, 0, 0, "R8");
    fetch(0);
    step(16'hB000, 0, 0, 0, 0, "R8");
    step(16'h0, 0, 0, 0, 0, "R8");
    step(16'h0, 0, 0, 0, 0, "R8");

    // constrained random instruction and memory stream
    for (int i = 0; i < 6000; i++) begin
      step(16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 3) == 0, "");
    end
    check(exp_tag, int'(state), exp_state);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule